// File: doc/BRIEF.md
# Synchronous Slave Serial Transceiver

This block is a half-duplex serial port that only ever acts as a slave. An external master drives the shift clock on `ck_in`, and one shared data line carries traffic in either direction. The line appears as `dt_in`, `dt_out` and `dt_oe`, so the pad tri-state sits outside the block. Both shift paths are clocked only by `ck_in`. A complete word can therefore arrive or leave while the system clock `clk` is halted. A finished word raises a flag, and the flag can pull the `irq` line to wake the processor.

Software reaches the port through a small register bus clocked by `clk`.
- Address 0 (data): a read returns the last received word and releases it. A write queues a word for transmission.
- Address 1 (control): a read/write register holding the direction bit, the two flag enables, the master interrupt gate and the receiver enable.
- Address 2 (status): a read-only register with the receive flag, the transmit-space flag and the overrun bit.

Transmit is double-buffered. One word can be shifting out while a second waits in a holding slot, and the waiting word moves into the shifter as soon as the previous one has been clocked out.

Top module: `sync_slave_port`

## Requirements
- R1: After reset, status (address 2) reads 0x02: bit0 receive flag = 0, bit1 transmit-space flag = 1, bit2 overrun = 0. After reset, `irq` = 0 and `dt_oe` = 0.
- R2: With control bit4 (receiver enable) = 1 and bit0 (direction) = 0, the block samples `dt_in` on each falling edge of `ck_in`, least significant bit first. After the 8th falling edge, the word can be read at address 0 and status bit0 is 1.
- R3: A read of address 0 while status bit0 is 1 clears status bit0.
- R4: If a word completes while the receive flag is still set, the new word is discarded, the data register keeps the old word, and status bit2 becomes 1. Status bit2 stays 1 until control is written with bit4 = 0.
- R5: With direction = 1, `dt_oe` = 1 and the queued word leaves least significant bit first. `dt_out` changes only on rising edges of `ck_in`, and bit k is valid after the (k+1)th rising edge of the word. With direction = 0, `dt_oe` = 0.
- R6: Up to two words can be queued: one in the shifter and one in the holding slot. Status bit1 is 1 while fewer than two words are outstanding, so it stays 1 after one write and becomes 0 after the second. After the 8th bit of the first word, the next rising edge of `ck_in` puts bit0 of the held word on `dt_out` and sets status bit1 again.
- R7: A write to address 0 while status bit1 is 0 is ignored, and the transmitted words are unchanged.
- R8: When a word finishes with nothing queued, `dt_out` keeps its last bit on further rising edges and status bit1 stays 1.
- R9: `irq` = control bit3 AND ((bit1 AND receive flag) OR (bit2 AND transmit-space flag)).
- R10: With `clk` stopped, a complete received word still sets the receive flag and raises `irq` when it is enabled. The word is readable once `clk` resumes.
- R11: Control (address 1) reads back the five bits last written: bit0 direction, bit1 receive enable for `irq`, bit2 transmit enable for `irq`, bit3 master gate, bit4 receiver enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-bus clock; may be stopped |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| ck_in | input | 1 | Shift clock from the external master |
| dt_in | input | 1 | Serial data from the line |
| dt_out | output | 1 | Serial data toward the line |
| dt_oe | output | 1 | Line driver enable, high in transmit direction |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe; a data read releases the received word |
| addr | input | 2 | Register select: 0 data, 1 control, 2 status |
| wdata | input | W | Bus write data |
| rdata | output | W | Bus read data, combinational from `addr` |
| irq | output | 1 | Wake/interrupt request, level, valid without `clk` |

## Verification
The checks rest on four assumptions about how the port is used.
- Direction, receiver enable and the bus-side queue pointer change only while `ck_in` is idle high.
- A data read happens in the gap between received words.
- The master never reverses direction in the middle of a word.
- `clk` runs whenever the bus is accessed.

The bench keeps within these limits by touching the bus only between complete words with `ck_in` parked high. Every received word is followed by several `clk` cycles before status is read, so the two-stage synchronizers have settled. Random bytes from a fixed seed feed both directions, alongside directed overrun, full-queue, idle-line and stopped-clock cases.

// File: rtl/sync_slave_port.sv
`timescale 1ns/1ps
module sync_slave_port #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ck_in,
  input  logic         dt_in,
  output logic         dt_out,
  output logic         dt_oe,
  input  logic         wr_en,
  input  logic         rd_en,
  input  logic [1:0]   addr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] rdata,
  output logic         irq
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] LAST = CW'(W - 1);
  localparam logic [1:0] A_DATA = 2'd0;
  localparam logic [1:0] A_CTRL = 2'd1;
  localparam logic [1:0] A_STAT = 2'd2;

  function automatic logic [1:0] g2b(input logic [1:0] g);
    return {g[1], g[1] ^ g[0]};
  endfunction
  function automatic logic [1:0] b2g(input logic [1:0] b);
    return {b[1], b[1] ^ b[0]};
  endfunction

  logic dir, rx_ie, tx_ie, pie, rx_en;
  logic [1:0] wr_ptr;
  logic [W-1:0] tx_buf [2];
  logic rx_clr_t;
  logic [1:0] rx_s, rd_s1, rd_s2;
  logic [2:0] ov_s;
  logic ov_flag;

  logic [W-2:0] rx_sh;
  logic [W-1:0] rx_data;
  logic [CW-1:0] rx_cnt;
  logic rx_set_t, ov_t;

  logic [W-1:0] tx_sh;
  logic [CW-1:0] tx_cnt;
  logic tx_busy;
  logic [1:0] rd_g;
  logic dt_q;

  wire [1:0] rd_bin     = g2b(rd_g);
  wire [1:0] rd_nx      = rd_bin + 2'd1;
  wire [1:0] tx_cnt_bus = wr_ptr - g2b(rd_s2);
  wire [1:0] tx_cnt_raw = wr_ptr - rd_bin;
  wire       tx_flag    = ~tx_cnt_bus[1];
  wire       tx_raw     = ~tx_cnt_raw[1];
  wire       rx_flag    = rx_s[1] ^ rx_clr_t;
  wire       rx_raw     = rx_set_t ^ rx_clr_t;
  wire [W-1:0] rx_next  = {dt_in, rx_sh};
  wire       ctrl_wr    = wr_en && addr == A_CTRL;
  wire       data_wr    = wr_en && addr == A_DATA && tx_flag;

  assign dt_out = dt_q;
  assign dt_oe  = dir;
  assign irq    = pie & ((rx_raw & rx_ie) | (tx_raw & tx_ie));

  always_comb begin
    case (addr)
      A_DATA:  rdata = rx_data;
      A_CTRL:  rdata = W'({rx_en, pie, tx_ie, rx_ie, dir});
      A_STAT:  rdata = W'({ov_flag, tx_flag, rx_flag});
      default: rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {rx_en, pie, tx_ie, rx_ie, dir} <= '0;
      wr_ptr   <= '0;
      rx_clr_t <= 1'b0;
      rx_s     <= '0;
      rd_s1    <= '0;
      rd_s2    <= '0;
      ov_s     <= '0;
      ov_flag  <= 1'b0;
    end else begin
      rx_s  <= {rx_s[0], rx_set_t};
      rd_s1 <= rd_g;
      rd_s2 <= rd_s1;
      ov_s  <= {ov_s[1:0], ov_t};
      if (ctrl_wr) {rx_en, pie, tx_ie, rx_ie, dir} <= wdata[4:0];
      if (data_wr) wr_ptr <= wr_ptr + 2'd1;
      if (rd_en && addr == A_DATA && rx_flag) rx_clr_t <= ~rx_clr_t;
      if (ov_s[2] ^ ov_s[1]) ov_flag <= 1'b1;
      else if (ctrl_wr && !wdata[4]) ov_flag <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (data_wr) tx_buf[wr_ptr[0]] <= wdata;
  end

  always_ff @(negedge ck_in or negedge rst_n) begin
    if (!rst_n) begin
      rx_sh    <= '0;
      rx_data  <= '0;
      rx_cnt   <= '0;
      rx_set_t <= 1'b0;
      ov_t     <= 1'b0;
    end else if (rx_en && !dir) begin
      rx_sh <= rx_next[W-1:1];
      if (rx_cnt == LAST) begin
        rx_cnt <= '0;
        if (!rx_raw) begin
          rx_data  <= rx_next;
          rx_set_t <= ~rx_set_t;
        end else begin
          ov_t <= ~ov_t;
        end
      end else begin
        rx_cnt <= rx_cnt + 1'b1;
      end
    end else begin
      rx_cnt <= '0;
    end
  end

  always_ff @(posedge ck_in or negedge rst_n) begin
    if (!rst_n) begin
      tx_sh   <= '0;
      tx_cnt  <= '0;
      tx_busy <= 1'b0;
      rd_g    <= '0;
      dt_q    <= 1'b0;
    end else if (dir) begin
      if (tx_busy && tx_cnt == LAST) begin
        rd_g <= b2g(rd_nx);
        if (wr_ptr != rd_nx) begin
          tx_sh  <= tx_buf[rd_nx[0]];
          dt_q   <= tx_buf[rd_nx[0]][0];
          tx_cnt <= '0;
        end else begin
          tx_busy <= 1'b0;
        end
      end else if (tx_busy) begin
        tx_sh  <= tx_sh >> 1;
        dt_q   <= tx_sh[1];
        tx_cnt <= tx_cnt + 1'b1;
      end else if (wr_ptr != rd_bin) begin
        tx_sh   <= tx_buf[rd_bin[0]];
        dt_q    <= tx_buf[rd_bin[0]][0];
        tx_busy <= 1'b1;
        tx_cnt  <= '0;
      end
    end
  end

  // R6
  tx_depth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_cnt_bus <= 2'd2);

  // R7
  tx_flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_flag) |-> $past(wr_en && addr == A_DATA));

  // R3
  rx_flag_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rx_flag) |-> $past(rd_en && addr == A_DATA));

  // R4
  rx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_flag |=> (!rx_flag || $stable(rx_data)));

  // R6
  tx_busy_chk: assert property (@(posedge ck_in) disable iff (!rst_n)
    tx_busy |-> (wr_ptr != rd_bin));
endmodule

// File: tb/test_sync_slave_port.sv
`timescale 1ns/1ps
module test_sync_slave_port;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0, clk_run = 1'b1;
  logic ck_in = 1'b1, dt_in = 1'b0;
  logic wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0] addr = '0;
  logic [W-1:0] wdata = '0;
  wire [W-1:0] rdata;
  wire dt_out, dt_oe, irq;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  sync_slave_port #(.W(W)) i_sync_slave_port (
    .clk(clk), .rst_n(rst_n), .ck_in(ck_in), .dt_in(dt_in),
    .dt_out(dt_out), .dt_oe(dt_oe), .wr_en(wr_en), .rd_en(rd_en),
    .addr(addr), .wdata(wdata), .rdata(rdata), .irq(irq));

  always #2.5 if (clk_run) clk = ~clk;

  function automatic logic [7:0] ctrl_v(bit rxen, bit gate, bit txie, bit rxie, bit d);
    return {3'b000, rxen, gate, txie, rxie, d};
  endfunction
  function automatic bit exp_irq(bit gate, bit rxie, bit txie, bit rxf, bit txf);
    return gate & ((rxie & rxf) | (txie & txf));
  endfunction
  function automatic logic [7:0] exp_stat(bit ov, bit txf, bit rxf);
    return {5'b0, ov, txf, rxf};
  endfunction

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
    end
  endtask

  task automatic bw(input logic [1:0] a, input logic [W-1:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic br(input logic [1:0] a, output logic [W-1:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic rx_word(input logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      dt_in = b[i]; #10 ck_in = 1'b0; #20 ck_in = 1'b1; #10;
    end
  endtask

  task automatic tx_edge(output logic bt);
    ck_in = 1'b0; #20 ck_in = 1'b1; #10 bt = dt_out; #10;
  endtask

  task automatic tx_word(output logic [7:0] b);
    for (int i = 0; i < 8; i++) begin
      logic bt;
      tx_edge(bt);
      b[i] = bt;
    end
  endtask

  initial begin
    #900000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog timeout actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [W-1:0] d;
    logic [7:0] a, b, c, got;
    logic bt;
    void'($urandom(32'd7741));
    #20 rst_n = 1'b1;
    settle();
    br(A_STAT(), d); chk("R1 status", d, exp_stat(0, 1, 0));
    chk("R1 irq", irq, 0);
    chk("R1 dt_oe", dt_oe, 0);

    bw(2'd1, ctrl_v(1, 1, 1, 1, 0));
    br(2'd1, d); chk("R11 ctrl readback", d, ctrl_v(1, 1, 1, 1, 0));
    chk("R9 irq tx enabled", irq, exp_irq(1, 1, 1, 0, 1));
    bw(2'd1, ctrl_v(1, 0, 1, 1, 0));
    chk("R9 irq gate off", irq, exp_irq(0, 1, 1, 0, 1));
    bw(2'd1, ctrl_v(1, 1, 0, 1, 0));
    br(2'd1, d); chk("R11 ctrl readback 2", d, ctrl_v(1, 1, 0, 1, 0));
    chk("R9 irq idle", irq, exp_irq(1, 1, 0, 0, 1));
    chk("R5 dt_oe receive", dt_oe, 0);

    for (int k = 0; k < 16; k++) begin
      a = 8'($urandom);
      rx_word(a);
      settle();
      br(2'd2, d); chk("R2 rx flag", d, exp_stat(0, 1, 1));
      chk("R9 irq rx", irq, exp_irq(1, 1, 0, 1, 1));
      br(2'd0, d); chk("R2 rx data", d, a);
      settle();
      br(2'd2, d); chk("R3 flag cleared", d, exp_stat(0, 1, 0));
    end

    a = 8'h5A; b = 8'hC3;
    rx_word(a); rx_word(b); settle();
    br(2'd2, d); chk("R4 overrun set", d, exp_stat(1, 1, 1));
    br(2'd0, d); chk("R4 old word kept", d, a);
    settle();
    br(2'd2, d); chk("R4 overrun sticky", d, exp_stat(1, 1, 0));
    bw(2'd1, ctrl_v(0, 1, 0, 1, 0));
    br(2'd2, d); chk("R4 overrun cleared", d, exp_stat(0, 1, 0));
    bw(2'd1, ctrl_v(1, 1, 0, 1, 0));
    settle();

    c = 8'($urandom);
    clk_run = 1'b0; #10;
    rx_word(c);
    #5 chk("R10 irq without clk", irq, 1);
    clk_run = 1'b1;
    settle();
    br(2'd0, d); chk("R10 word after resume", d, c);
    settle();

    bw(2'd1, ctrl_v(0, 0, 0, 0, 1));
    settle();
    chk("R5 dt_oe transmit", dt_oe, 1);

    a = 8'hB4;
    bw(2'd0, a); settle();
    br(2'd2, d); chk("R6 one word queued", d, exp_stat(0, 1, 0));
    tx_word(got); chk("R5 single word", got, a);
    tx_edge(bt); chk("R8 idle holds last bit", bt, a[7]);
    tx_edge(bt); chk("R8 idle holds again", bt, a[7]);
    settle();
    br(2'd2, d); chk("R8 flag stays", d, exp_stat(0, 1, 0));

    for (int k = 0; k < 8; k++) begin
      a = 8'($urandom); b = 8'($urandom); c = ~b;
      bw(2'd0, a); bw(2'd0, b); settle();
      br(2'd2, d); chk("R6 queue full", d, exp_stat(0, 0, 0));
      bw(2'd0, c);
      tx_word(got); chk("R5 first word", got, a);
      settle();
      br(2'd2, d); chk("R6 still full", d, exp_stat(0, 0, 0));
      tx_edge(bt); got[0] = bt;
      settle();
      br(2'd2, d); chk("R6 reload sets flag", d, exp_stat(0, 1, 0));
      for (int i = 1; i < 8; i++) begin
        tx_edge(bt); got[i] = bt;
      end
      chk("R7 second word unchanged", got, b);
      tx_edge(bt); chk("R8 last bit held", bt, b[7]);
      tx_edge(bt); chk("R8 last bit held 2", bt, b[7]);
      settle();
      br(2'd2, d); chk("R8 no repeat event", d, exp_stat(0, 1, 0));
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  function automatic logic [1:0] A_STAT();
    return 2'd2;
  endfunction
endmodule